// File: doc/BRIEF.md
# Configurable-Trigger Interrupt Controller

This block collects up to 32 interrupt request lines and presents them to a processor as two outputs: a normal interrupt and a fast interrupt. Each line has its own sensing rule. It can follow a live level, active high or active low, or it can capture a rising or falling transition. A captured transition stays latched until software acknowledges it by writing a one to that line's bit.

Software reaches seven 32-bit word registers through a simple single-cycle write strobe and a combinational read port. Five of them configure or act on the lines: sensing kind, polarity, blocking, output routing and acknowledge. The other two are read-only: the raw per-line status, and an encoded index of the next line to service. Every input passes through a two-stage synchroniser before it is sensed.

Register map (word address on `bus_addr`): 0 = sense kind, 1 = polarity, 2 = block, 3 = fast route, 4 = acknowledge (write-only, reads 0), 5 = status (read-only), 6 = next index (read-only).

Top module: `trig_irq_ctrl`

## Requirements
- R1: After reset, address 2 (block) reads 0xFFFFFFFF. Addresses 0, 1 and 3 read 0. Both outputs are low, and bit 8 of address 6 is 0.
- R2: A line with sense-kind bit 0 and polarity bit 0 shows status bit 1 (address 5) while its input is high, within 3 cycles. The bit returns to 0 within 3 cycles of the input going low.
- R3: A line with sense-kind bit 0 and polarity bit 1 shows status 1 while its input is low and 0 while it is high.
- R4: A line with sense-kind bit 1 and polarity bit 0 latches status 1 on a 0-to-1 input transition, including a one-cycle pulse. The bit stays 1 after the input returns low.
- R5: A line with sense-kind bit 1 and polarity bit 1 latches only on a 1-to-0 transition. A 0-to-1 transition leaves its status at 0.
- R6: Writing address 4 clears the latch of every line whose data bit is 1. Lines whose data bit is 0 keep their latch, and address 4 reads 0.
- R7: A line whose block bit is 1 still shows its status, but it drives neither output and is not reported at address 6.
- R8: An unblocked pending line with fast-route bit 0 drives `irq_o` only. With fast-route bit 1 it drives `fiq_o` only.
- R9: Address 6 returns the lowest-numbered unblocked pending line in bits [4:0], with bit 8 set. Bit 8 is 0 when no line is unblocked and pending.
- R10: Transitions seen while a line is in level mode (sense-kind 0) are not latched. Switching that line to edge mode afterwards shows status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_lines | input | 32 | Raw interrupt request inputs, asynchronous |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
A stuck or lost edge latch appears at address 5 within three cycles of the stimulus, and it stays visible because it does not decay on its own. A wrong polarity, sense-kind or block bit changes the status word, the two output pins and the encoded index together. Each scenario therefore reads all of them after a fixed settle of three cycles. A faulty encoder shows up at once as a wrong index whenever two or more lines are pending, so the priority scenario drives widely separated lines and then blocks the winner.

// File: rtl/trig_irq_pkg.sv
package trig_irq_pkg;
  typedef enum logic [2:0] {
    RA_KIND   = 3'd0,
    RA_POL    = 3'd1,
    RA_BLOCK  = 3'd2,
    RA_ROUTE  = 3'd3,
    RA_ACK    = 3'd4,
    RA_STATUS = 3'd5,
    RA_NEXT   = 3'd6
  } reg_addr_e;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned VALID_BIT = 8;
endpackage

// File: rtl/tic_sync.sv
module tic_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg1_q, stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else begin
      stg1_q <= async_i;
      stg2_q <= stg1_q;
    end
  end

  assign sync_o = stg2_q;
endmodule

// File: rtl/tic_sense.sv
module tic_sense #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_i,
  input  logic [N-1:0] kind_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] latch_q, latch_d;
  logic [N-1:0] active, active_prev, event_hit;

  // Polarity applied to both samples, so a polarity change cannot fake an edge
  assign active      = line_i ^ pol_i;
  assign active_prev = prev_q ^ pol_i;
  assign event_hit   = active & ~active_prev & kind_i;

  // A new event in the same cycle as its clear wins
  always_comb begin
    latch_d = (latch_q & ~clr_i) | event_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= line_i;
      latch_q <= latch_d;
    end
  end

  generate
    for (genvar g = 0; g < N; g++) begin : g_stat
      assign status_o[g] = kind_i[g] ? latch_q[g] : active[g];
    end
  endgenerate

  // R6: an uncleared latch stays set
  a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((latch_q & ~clr_i) != '0) |=> ((latch_q & $past(latch_q & ~clr_i)) == $past(latch_q & ~clr_i)));

  // R10: a latch may only rise for a line that was in edge mode
  a_r10_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((latch_q & ~$past(latch_q) & ~$past(kind_i)) == '0));
endmodule

// File: rtl/tic_lowpick.sv
module tic_lowpick #(
  parameter int unsigned N = 32,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          valid_o
);
  always_comb begin
    idx_o   = '0;
    valid_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o   = IW'(i);
        valid_o = 1'b1;
      end
    end
  end

  // R9: the reported line is requesting and nothing below it is
  a_r9_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (req_i[idx_o] && ((req_i & ((N'(1) << idx_o) - N'(1))) == '0)));

  a_r9_none_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == '0) |-> !valid_o);
endmodule

// File: rtl/trig_irq_ctrl.sv
module trig_irq_ctrl
  import trig_irq_pkg::*;
#(
  parameter int unsigned N_LINES = 32,
  localparam int unsigned IW = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [2:0]           bus_addr,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  input  logic [N_LINES-1:0]   irq_lines,
  output logic                 irq_o,
  output logic                 fiq_o
);
  logic [N_LINES-1:0] kind_q, kind_d;
  logic [N_LINES-1:0] pol_q, pol_d;
  logic [N_LINES-1:0] block_q, block_d;
  logic [N_LINES-1:0] route_q, route_d;
  logic [N_LINES-1:0] ack_vec;
  logic [N_LINES-1:0] synced, status, pend;
  logic [IW-1:0]      nxt_idx;
  logic               nxt_valid;
  logic [WORD_W-1:0]  nxt_word;
  logic               we_kind, we_pol, we_block, we_route, we_ack;

  assign we_kind  = bus_wr && (bus_addr == RA_KIND);
  assign we_pol   = bus_wr && (bus_addr == RA_POL);
  assign we_block = bus_wr && (bus_addr == RA_BLOCK);
  assign we_route = bus_wr && (bus_addr == RA_ROUTE);
  assign we_ack   = bus_wr && (bus_addr == RA_ACK);

  always_comb begin
    kind_d  = we_kind  ? bus_wdata[N_LINES-1:0] : kind_q;
    pol_d   = we_pol   ? bus_wdata[N_LINES-1:0] : pol_q;
    block_d = we_block ? bus_wdata[N_LINES-1:0] : block_q;
    route_d = we_route ? bus_wdata[N_LINES-1:0] : route_q;
    ack_vec = we_ack   ? bus_wdata[N_LINES-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= '0;
      pol_q   <= '0;
      block_q <= '1;
      route_q <= '0;
    end else begin
      kind_q  <= kind_d;
      pol_q   <= pol_d;
      block_q <= block_d;
      route_q <= route_d;
    end
  end

  tic_sync #(.W(N_LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(irq_lines), .sync_o(synced)
  );

  tic_sense #(.N(N_LINES)) u_sense (
    .clk(clk), .rst_n(rst_n), .line_i(synced), .kind_i(kind_q),
    .pol_i(pol_q), .clr_i(ack_vec), .status_o(status)
  );

  assign pend  = status & ~block_q;
  assign irq_o = |(pend & ~route_q);
  assign fiq_o = |(pend & route_q);

  tic_lowpick #(.N(N_LINES)) u_pick (
    .clk(clk), .rst_n(rst_n), .req_i(pend), .idx_o(nxt_idx), .valid_o(nxt_valid)
  );

  always_comb begin
    nxt_word            = '0;
    nxt_word[IW-1:0]    = nxt_idx;
    nxt_word[VALID_BIT] = nxt_valid;
  end

  always_comb begin
    case (bus_addr)
      RA_KIND:   bus_rdata = WORD_W'(kind_q);
      RA_POL:    bus_rdata = WORD_W'(pol_q);
      RA_BLOCK:  bus_rdata = WORD_W'(block_q);
      RA_ROUTE:  bus_rdata = WORD_W'(route_q);
      RA_STATUS: bus_rdata = WORD_W'(status);
      RA_NEXT:   bus_rdata = nxt_word;
      default:   bus_rdata = '0;
    endcase
  end

  // R7: with every line blocked both outputs stay quiet
  a_r7_all_blocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (block_q == '1) |-> (!irq_o && !fiq_o));

  // R8: no fast-routed line means the fast output is idle
  a_r8_no_route_no_fiq: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q == '0) |-> !fiq_o);

  // R9: an output is active exactly when a line is reported
  a_r9_out_matches_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o || fiq_o) == nxt_valid);
endmodule

// File: tb/trig_irq_ctrl_test.sv
`timescale 1ns/1ps
module trig_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] irq_lines;
  logic        irq_o, fiq_o;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  trig_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lines(irq_lines),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic restore();
    irq_lines = '0;
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h0);
    wr(3'd3, 32'h0);
    settle();
    wr(3'd4, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd2, v); chk("R1 block reset", v, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R1 kind reset", v, 32'h0);
    rd(3'd1, v); chk("R1 pol reset", v, 32'h0);
    rd(3'd3, v); chk("R1 route reset", v, 32'h0);
    rd(3'd6, v); chk("R1 next invalid", {31'b0, v[8]}, 32'h0);
    chk("R1 outputs low", {30'b0, irq_o, fiq_o}, 32'h0);
  endtask

  task automatic t_level_high();
    logic [31:0] v;
    wr(3'd2, ~32'h20);
    irq_lines[5] = 1'b1; settle();
    rd(3'd5, v); chk("R2 level high status", v, 32'h20);
    chk("R2 irq asserted", {31'b0, irq_o}, 32'h1);
    irq_lines[5] = 1'b0; settle();
    rd(3'd5, v); chk("R2 level drop status", v, 32'h0);
    chk("R2 irq released", {31'b0, irq_o}, 32'h0);
    restore();
  endtask

  task automatic t_level_low();
    logic [31:0] v;
    wr(3'd1, 32'h40);
    settle();
    rd(3'd5, v); chk("R3 active-low idle pending", v, 32'h40);
    irq_lines[6] = 1'b1; settle();
    rd(3'd5, v); chk("R3 active-low high clears", v, 32'h0);
    restore();
  endtask

  task automatic t_edge_rise_ack();
    logic [31:0] v;
    wr(3'd0, 32'h0000_0300);
    @(negedge clk); irq_lines[9] = 1'b1; irq_lines[8] = 1'b1;
    @(negedge clk); irq_lines[9] = 1'b0; irq_lines[8] = 1'b0;
    settle();
    rd(3'd5, v); chk("R4 rising pulse latched", v, 32'h0000_0300);
    wr(3'd4, 32'h0000_0200);
    rd(3'd5, v); chk("R6 ack clears only line 9", v, 32'h0000_0100);
    rd(3'd4, v); chk("R6 ack reads zero", v, 32'h0);
    restore();
  endtask

  task automatic t_edge_fall();
    logic [31:0] v;
    wr(3'd0, 32'h400);
    wr(3'd1, 32'h400);
    irq_lines[10] = 1'b1; settle();
    rd(3'd5, v); chk("R5 rise ignored on falling line", v, 32'h0);
    irq_lines[10] = 1'b0; settle();
    rd(3'd5, v); chk("R5 fall latched", v, 32'h400);
    restore();
  endtask

  task automatic t_block_route();
    logic [31:0] v;
    irq_lines[3] = 1'b1; settle();
    rd(3'd5, v); chk("R7 blocked still in status", v, 32'h8);
    rd(3'd6, v); chk("R7 blocked not reported", {31'b0, v[8]}, 32'h0);
    chk("R7 blocked outputs low", {30'b0, irq_o, fiq_o}, 32'h0);
    wr(3'd3, 32'h8);
    wr(3'd2, ~32'h8);
    chk("R8 fast route", {30'b0, irq_o, fiq_o}, 32'h1);
    wr(3'd3, 32'h0);
    chk("R8 normal route", {30'b0, irq_o, fiq_o}, 32'h2);
    restore();
  endtask

  task automatic t_priority();
    logic [31:0] v;
    wr(3'd2, 32'h0);
    irq_lines = 32'h8002_0010; settle();
    rd(3'd6, v); chk("R9 lowest is 4", v, 32'h104);
    wr(3'd2, 32'h10);
    rd(3'd6, v); chk("R9 next is 17", v, 32'h111);
    wr(3'd2, 32'h0002_0010);
    rd(3'd6, v); chk("R9 top line 31", v, 32'h11F);
    restore();
  endtask

  task automatic t_level_no_latch();
    logic [31:0] v;
    wr(3'd2, ~32'h1000);
    @(negedge clk); irq_lines[12] = 1'b1;
    @(negedge clk); irq_lines[12] = 1'b0;
    settle();
    wr(3'd0, 32'h1000);
    rd(3'd5, v); chk("R10 no latch from level mode", v, 32'h0);
    chk("R10 no irq", {31'b0, irq_o}, 32'h0);
    restore();
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; irq_lines = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_level_high();
    t_level_low();
    t_edge_rise_ack();
    t_edge_fall();
    t_block_route();
    t_priority();
    t_level_no_latch();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule